// File: doc/BRIEF.md
# Partitioned Subword SIMD Adder

A 64-bit add/subtract datapath that treats its operands either as one full-width number or as a row of packed, independent lanes of 8, 16 or 32 bits. A single wide adder serves every lane configuration. Lanes are isolated by stopping the carry at each lane boundary, so one pass yields eight, four, two or one independent sums.

Besides add and subtract, the block offers a fused average and two fused shift-then-add operations. The shift-then-add operations scale the second operand by a power of two (left by up to three bits, or right by up to three bits) before accumulating it into the first operand. These give cheap multiply-by-constant primitives. Each lane handles overflow in one of three ways: it wraps, it clamps to the signed range, or it clamps to the unsigned range.

The result is registered, so it appears on the output one clock after the inputs are presented. The integrating pipeline supplies operands and controls each cycle and reads the result on the following cycle.

Top module: `psimd_adder`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, `result_o` becomes zero at that edge. Otherwise `result_o` takes, at each rising edge, the value computed from the inputs present before that edge.
- R2: `lane_sel_i` selects the lane width: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. No carry or borrow passes from one lane into the next; for example, in 16-bit lanes, 0xFFFF + 1 in lane 0 leaves lane 1 unchanged.
- R3: With `mode_i` = 0 (wrap), add (`op_i` = 0) gives (a + b) mod 2^n per n-bit lane, and subtract (`op_i` = 1) gives (a - b) mod 2^n per lane. For example, 8-bit 0xFF + 0x01 gives 0x00.
- R4: With `mode_i` = 1 (signed clamp), a lane whose true two's-complement result exceeds the largest signed value yields that largest value (0x7F.. pattern). A lane whose true result falls below the smallest signed value yields that smallest value (0x80.. pattern).
- R5: With `mode_i` = 2 (unsigned clamp), a lane whose true result exceeds 2^n - 1 yields all ones, and a lane whose true result is negative yields zero.
- R6: Average (`op_i` = 2) gives floor((a + b) / 2) per lane, with both lane values taken as unsigned. It never overflows, and its result does not depend on `mode_i`.
- R7: Shift-left-add (`op_i` = 3) shifts each lane of b left by `shamt_i` (0 to 3) bits, filling with zeros and dropping the bits that leave the lane. It then adds the shifted value to a, applying the overflow mode of R3 to R5.
- R8: Shift-right-add (`op_i` = 4) shifts each lane of b right by `shamt_i` bits before adding it to a under the selected overflow mode. The shift fills with the lane's sign bit when `mode_i` = 1 and with zeros otherwise.
- R9: The unassigned `op_i` codes 5 to 7 act as add. `mode_i` = 3 acts as wrap. `shamt_i` has no effect on add, subtract or average.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opa_i | input | 64 | First operand, packed lanes |
| opb_i | input | 64 | Second operand, packed lanes; shifted in shift-add operations |
| op_i | input | 3 | Operation: 0 add, 1 subtract, 2 average, 3 shift-left-add, 4 shift-right-add |
| mode_i | input | 2 | Overflow handling: 0 wrap, 1 signed clamp, 2 unsigned clamp |
| lane_sel_i | input | 2 | Lane width: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit, 3 is 64-bit |
| shamt_i | input | 2 | Pre-shift distance for shift-add operations |
| result_o | output | 64 | Registered packed result |

## Verification
The bench builds the block with its default parameters: a 64-bit datapath, 8-bit segments and four lane widths. With these values, the narrowest lanes, where every segment is a lane top, and the single full-width lane, whose carry leaves the top of the adder, are exercised in one build. Directed vectors drive the clamp boundaries, borrow-to-zero, carry isolation at lane edges, and sign fill in the right shift. A few thousand random vectors then mix every operation, mode, width and shift distance, and a per-lane arithmetic model checks each result.

// File: rtl/psimd_pkg.sv
// Shared encodings for the partitioned subword adder.
// Assumes op, mode and lane-select codes are driven as listed here.
package psimd_pkg;
    localparam logic [2:0] OP_ADD     = 3'd0;
    localparam logic [2:0] OP_SUB     = 3'd1;
    localparam logic [2:0] OP_AVG     = 3'd2;
    localparam logic [2:0] OP_SHL_ADD = 3'd3;
    localparam logic [2:0] OP_SHR_ADD = 3'd4;

    localparam logic [1:0] MODE_WRAP     = 2'd0;
    localparam logic [1:0] MODE_SIGNED   = 2'd1;
    localparam logic [1:0] MODE_UNSIGNED = 2'd2;
endpackage

// File: rtl/psimd_preshift.sv
// Forms the effective second operand for the adder: the plain operand,
// its inverse for subtract, or a per-lane shifted copy for the shift-add
// operations. Assumes DATA_W is a multiple of the widest lane.
module psimd_preshift
    import psimd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 8,
    parameter int NUM_W  = 4,
    localparam int WSEL_W = $clog2(NUM_W)
) (
    input  logic [DATA_W-1:0] opb,
    input  logic [2:0]        op,
    input  logic [1:0]        mode,
    input  logic [WSEL_W-1:0] lane_sel,
    input  logic [1:0]        shamt,
    output logic [DATA_W-1:0] b_eff
);
    logic [DATA_W-1:0] shl_all [NUM_W];
    logic [DATA_W-1:0] shr_all [NUM_W];

    for (genvar w = 0; w < NUM_W; w++) begin : g_w
        localparam int LW = SEG_W << w;
        localparam int NL = DATA_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_l
            logic [LW-1:0]   lane;
            logic            fill;
            logic [2*LW-1:0] wide;
            assign lane = opb[l*LW +: LW];
            assign fill = (mode == MODE_SIGNED) & lane[LW-1];
            assign wide = {{LW{fill}}, lane} >> shamt;
            // left shift stays inside the lane, zero fill
            assign shl_all[w][l*LW +: LW] = lane << shamt;
            // right shift stays inside the lane, sign or zero fill
            assign shr_all[w][l*LW +: LW] = wide[LW-1:0];
        end
    end

    // choose the operand presented to the adder
    always_comb begin
        case (op)
            OP_SUB:     b_eff = ~opb;
            OP_SHL_ADD: b_eff = shl_all[lane_sel];
            OP_SHR_ADD: b_eff = shr_all[lane_sel];
            default:    b_eff = opb;
        endcase
    end
endmodule

// File: rtl/psimd_cut_adder.sv
// One wide adder split into lanes. A spare bit sits above every segment.
// At a lane boundary it absorbs the lane's carry-out and injects the next
// lane's carry-in. Inside a lane it passes the carry through. seg_cout is
// valid only for segments that are lane tops.
module psimd_cut_adder #(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 8,
    parameter int NUM_W  = 4,
    localparam int WSEL_W = $clog2(NUM_W),
    localparam int NSEG   = DATA_W / SEG_W,
    localparam int STRIDE = SEG_W + 1,
    localparam int EXT_W  = NSEG * STRIDE
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [WSEL_W-1:0] lane_sel,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic [NSEG-1:0]   seg_cout
);
    logic [EXT_W-1:0] ext_a;
    logic [EXT_W-1:0] ext_b;
    logic [EXT_W-1:0] ext_s;

    // interleave segments with separator bits chosen by lane width
    always_comb begin
        int segs;
        segs = 1 << lane_sel;
        ext_a = '0;
        ext_b = '0;
        for (int i = 0; i < NSEG; i++) begin
            ext_a[i*STRIDE +: SEG_W] = a[i*SEG_W +: SEG_W];
            ext_b[i*STRIDE +: SEG_W] = b[i*SEG_W +: SEG_W];
            if (i < NSEG - 1) begin
                if (((i + 1) % segs) == 0) begin
                    ext_a[i*STRIDE + SEG_W] = cin;
                    ext_b[i*STRIDE + SEG_W] = cin;
                end else begin
                    ext_a[i*STRIDE + SEG_W] = 1'b1;
                    ext_b[i*STRIDE + SEG_W] = 1'b0;
                end
            end
        end
    end

    // the single shared addition
    assign ext_s = ext_a + ext_b + {{(EXT_W-1){1'b0}}, cin};

    // strip separators back out
    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        assign sum[i*SEG_W +: SEG_W] = ext_s[i*STRIDE +: SEG_W];
        assign seg_cout[i]           = ext_s[i*STRIDE + SEG_W];
    end
endmodule

// File: rtl/psimd_lane_fix.sv
// Finishes each lane: turns the raw sum into an average or applies the
// wrap, signed-clamp or unsigned-clamp rule. Assumes a_top and b_top
// carry the top bit of each segment of the adder's two inputs.
module psimd_lane_fix
    import psimd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 8,
    parameter int NUM_W  = 4,
    localparam int WSEL_W = $clog2(NUM_W),
    localparam int NSEG   = DATA_W / SEG_W
) (
    input  logic [DATA_W-1:0] sum,
    input  logic [NSEG-1:0]   seg_cout,
    input  logic [NSEG-1:0]   a_top,
    input  logic [NSEG-1:0]   b_top,
    input  logic [2:0]        op,
    input  logic [1:0]        mode,
    input  logic [WSEL_W-1:0] lane_sel,
    output logic [DATA_W-1:0] res
);
    logic [DATA_W-1:0] res_all [NUM_W];

    for (genvar w = 0; w < NUM_W; w++) begin : g_w
        localparam int LW = SEG_W << w;
        localparam int NL = DATA_W / LW;
        localparam int SPL = LW / SEG_W;
        for (genvar l = 0; l < NL; l++) begin : g_l
            localparam int TOP = (l + 1) * SPL - 1;
            logic [LW-1:0] s;
            logic [LW-1:0] r;
            logic          c, am, bm, ov;
            assign s  = sum[l*LW +: LW];
            assign c  = seg_cout[TOP];
            assign am = a_top[TOP];
            assign bm = b_top[TOP];
            assign ov = (am == bm) && (s[LW-1] != am);

            // per-lane finishing rule
            always_comb begin
                if (op == OP_AVG) begin
                    r = {c, s[LW-1:1]};
                end else if (mode == MODE_UNSIGNED) begin
                    if (op == OP_SUB) r = c ? s : '0;
                    else              r = c ? '1 : s;
                end else if (mode == MODE_SIGNED) begin
                    if (ov) r = am ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
                    else    r = s;
                end else begin
                    r = s;
                end
            end
            assign res_all[w][l*LW +: LW] = r;
        end
    end

    assign res = res_all[lane_sel];
endmodule

// File: rtl/psimd_adder.sv
// Top of the partitioned subword adder: preshift, shared carry-cut adder,
// per-lane finish, then one result register with synchronous active-low
// reset. Assumes SEG_W << (NUM_W-1) equals DATA_W.
module psimd_adder
    import psimd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 8,
    parameter int NUM_W  = 4,
    localparam int WSEL_W = $clog2(NUM_W),
    localparam int NSEG   = DATA_W / SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [2:0]        op_i,
    input  logic [1:0]        mode_i,
    input  logic [WSEL_W-1:0] lane_sel_i,
    input  logic [1:0]        shamt_i,
    output logic [DATA_W-1:0] result_o
);
    localparam logic [WSEL_W-1:0] FULL_SEL = WSEL_W'(NUM_W - 1);

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] sum_w;
    logic [NSEG-1:0]   seg_cout;
    logic [NSEG-1:0]   a_top, b_top;
    logic [DATA_W-1:0] res_c;
    logic              cin;

    assign cin = (op_i == OP_SUB);

    for (genvar i = 0; i < NSEG; i++) begin : g_top
        assign a_top[i] = opa_i[i*SEG_W + SEG_W - 1];
        assign b_top[i] = b_eff[i*SEG_W + SEG_W - 1];
    end

    psimd_preshift #(.DATA_W(DATA_W), .SEG_W(SEG_W), .NUM_W(NUM_W)) u_preshift (
        .opb(opb_i), .op(op_i), .mode(mode_i), .lane_sel(lane_sel_i),
        .shamt(shamt_i), .b_eff(b_eff)
    );

    psimd_cut_adder #(.DATA_W(DATA_W), .SEG_W(SEG_W), .NUM_W(NUM_W)) u_adder (
        .a(opa_i), .b(b_eff), .lane_sel(lane_sel_i), .cin(cin),
        .sum(sum_w), .seg_cout(seg_cout)
    );

    psimd_lane_fix #(.DATA_W(DATA_W), .SEG_W(SEG_W), .NUM_W(NUM_W)) u_fix (
        .sum(sum_w), .seg_cout(seg_cout), .a_top(a_top), .b_top(b_top),
        .op(op_i), .mode(mode_i), .lane_sel(lane_sel_i), .res(res_c)
    );

    // result register
    always_ff @(posedge clk) begin
        if (!rst_n) result_o <= '0;
        else        result_o <= res_c;
    end

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> result_o == '0); // R1
    AST_WRAP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_WRAP && (op_i == OP_ADD || op_i == OP_SUB)) |=> result_o == $past(sum_w)); // R3
    AST_SIGNED_KEEPS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel_i == FULL_SEL && mode_i == MODE_SIGNED && op_i == OP_ADD && opa_i[DATA_W-1] == opb_i[DATA_W-1])
        |=> result_o[DATA_W-1] == $past(opa_i[DATA_W-1])); // R4
    AST_UNS_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel_i == FULL_SEL && mode_i == MODE_UNSIGNED && op_i == OP_ADD && seg_cout[NSEG-1])
        |=> result_o == '1); // R5
    AST_AVG_TOP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel_i == FULL_SEL && op_i == OP_AVG) |=> result_o[DATA_W-1] == $past(seg_cout[NSEG-1])); // R6
endmodule

// File: tb/psimd_adder_bench.sv
`timescale 1ns/1ps
module psimd_adder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic [2:0]  op = '0;
    logic [1:0]  mode = '0, lane_sel = '0, shamt = '0;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    psimd_adder u_psimd_adder (
        .clk(clk), .rst_n(rst_n), .opa_i(opa), .opb_i(opb), .op_i(op),
        .mode_i(mode), .lane_sel_i(lane_sel), .shamt_i(shamt), .result_o(result)
    );

    // reference for one lane of width lw, values in the low lw bits
    function automatic logic [63:0] lane_ref(logic [63:0] a, logic [63:0] b, int lw,
                                             logic [2:0] o, logic [1:0] m, logic [1:0] k);
        logic [63:0] mask, bp, bx;
        logic signed [63:0] bs;
        logic signed [67:0] ua, ub, sa, sb, r, mx, mn, top;
        logic [2:0] eo;
        logic [1:0] em;
        mask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
        eo = (o > 3'd4) ? 3'd0 : o;
        em = (m == 2'd3) ? 2'd0 : m;
        bp = b;
        if (eo == 3'd3) bp = (b << k) & mask;
        if (eo == 3'd4) begin
            if (em == 2'd1 && b[lw-1]) bx = b | ~mask;
            else                       bx = b;
            bs = bx;
            bp = (em == 2'd1) ? (64'(bs >>> k) & mask) : (b >> k);
        end
        ua = {4'b0, a};
        ub = {4'b0, bp};
        sa = a[lw-1] ? {4'hF, a | ~mask} : ua;
        sb = bp[lw-1] ? {4'hF, bp | ~mask} : ub;
        top = {4'b0, mask};
        if (eo == 3'd2) begin
            r = (ua + ub) >>> 1;
            return r[63:0] & mask;
        end
        if (em == 2'd1) r = (eo == 3'd1) ? (sa - sb) : (sa + sb);
        else            r = (eo == 3'd1) ? (ua - ub) : (ua + ub);
        if (em == 2'd2) begin
            if (r < 0)        r = 0;
            else if (r > top) r = top;
        end else if (em == 2'd1) begin
            mx = {4'b0, mask >> 1};
            mn = -mx - 1;
            if (r > mx)      r = mx;
            else if (r < mn) r = mn;
        end
        return r[63:0] & mask;
    endfunction

    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic [2:0] o,
                                          logic [1:0] m, logic [1:0] w, logic [1:0] k);
        int lw;
        logic [63:0] res, mask, la, lb;
        lw = 8 << w;
        mask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
        res = '0;
        for (int l = 0; l < 64 / lw; l++) begin
            la = (a >> (l * lw)) & mask;
            lb = (b >> (l * lw)) & mask;
            res = res | (lane_ref(la, lb, lw, o, m, k) << (l * lw));
        end
        return res;
    endfunction

    // driver: present one vector and queue its expected result
    task automatic apply(logic [63:0] a, logic [63:0] b, logic [2:0] o, logic [1:0] m,
                         logic [1:0] w, logic [1:0] k, string tag);
        @(negedge clk);
        opa = a; opb = b; op = o; mode = m; lane_sel = w; shamt = k;
        exp_q.push_back(model(a, b, o, m, w, k));
        tag_q.push_back(tag);
    endtask

    // monitor: compare each registered result one edge after its vector
    initial begin
        logic [63:0] e;
        string t;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (result !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", t, result, e);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        opa = 64'hDEAD_BEEF_0123_4567; opb = 64'h1111_2222_3333_4444;
        repeat (3) @(negedge clk);
        n_checks++;
        if (result !== 64'd0) begin
            n_fail++;
            $display("FAIL R1 reset: actual %h expected %h", result, 64'd0);
        end
        rst_n = 1'b1;

        // R3 wraparound: 8-bit 0xFF + 1 -> 0, and subtract
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 3'd0, 2'd0, 2'd0, 2'd0, "R3 wrap 8b add");
        apply(64'h0000_0005_0010_0003, 64'h0001_0007_0001_0004, 3'd1, 2'd0, 2'd1, 2'd0, "R3 wrap 16b sub");
        // R2 carry isolation at lane edges
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 3'd0, 2'd0, 2'd1, 2'd0, "R2 16b carry cut");
        apply(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 3'd0, 2'd0, 2'd2, 2'd0, "R2 32b carry cut");
        apply(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 3'd0, 2'd0, 2'd3, 2'd0, "R2 64b carry runs");
        apply(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 3'd1, 2'd0, 2'd0, 2'd0, "R2 8b borrow cut");
        // R4 signed clamp both directions
        apply(64'h7FFF_8000_7FFF_0001, 64'h0001_FFFF_7FFF_0001, 3'd0, 2'd1, 2'd1, 2'd0, "R4 signed add clamp");
        apply(64'h8000_7FFF_0000_0005, 64'h0001_FFFF_0001_0003, 3'd1, 2'd1, 2'd1, 2'd0, "R4 signed sub clamp");
        apply(64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 3'd0, 2'd1, 2'd3, 2'd0, "R4 signed 64b clamp");
        // R5 unsigned clamp high and low
        apply(64'hFF80_01FE_0000_0000, 64'h0180_01FF_0000_0001, 3'd0, 2'd2, 2'd0, 2'd0, "R5 unsigned add clamp");
        apply(64'h0000_0003_0010_0000, 64'h0001_0004_0001_FFFF, 3'd1, 2'd2, 2'd1, 2'd0, "R5 unsigned sub to zero");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, 3'd0, 2'd2, 2'd3, 2'd0, "R5 unsigned 64b clamp");
        // R6 average, all modes alike
        apply(64'hFFFF_0001_8000_0003, 64'hFFFF_0002_8000_0004, 3'd2, 2'd0, 2'd1, 2'd0, "R6 avg wrap");
        apply(64'hFFFF_0001_8000_0003, 64'hFFFF_0002_8000_0004, 3'd2, 2'd1, 2'd1, 2'd0, "R6 avg signed");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 3'd2, 2'd2, 2'd3, 2'd0, "R6 avg 64b");
        // R7 shift-left-add
        apply(64'h0001_0002_0003_0004, 64'h0003_1000_0FFF_0001, 3'd3, 2'd0, 2'd1, 2'd3, "R7 shl3 wrap");
        apply(64'h0001_0002_0003_0004, 64'h0003_1000_0FFF_0001, 3'd3, 2'd2, 2'd1, 2'd2, "R7 shl2 unsigned");
        apply(64'h0010_0020_7000_0004, 64'h0003_1000_1FFF_0001, 3'd3, 2'd1, 2'd1, 2'd1, "R7 shl1 signed");
        // R8 shift-right-add, sign fill only in signed mode
        apply(64'h0000_0000_0000_0000, 64'h8000_8000_F000_0010, 3'd4, 2'd1, 2'd1, 2'd1, "R8 shr signed fill");
        apply(64'h0000_0000_0000_0000, 64'h8000_8000_F000_0010, 3'd4, 2'd0, 2'd1, 2'd1, "R8 shr zero fill");
        apply(64'h0101_0101_0101_0101, 64'h8080_F0F0_0808_FFFF, 3'd4, 2'd2, 2'd0, 2'd3, "R8 shr3 unsigned");
        // R9 spare codes and ignored shift distance
        apply(64'h00FF_7FFF_0001_1234, 64'h0001_0001_0001_1111, 3'd7, 2'd3, 2'd1, 2'd3, "R9 spare op and mode");
        apply(64'h00FF_7FFF_0001_1234, 64'h0001_0001_0001_1111, 3'd0, 2'd0, 2'd1, 2'd3, "R9 shamt ignored add");
        apply(64'h00FF_7FFF_0001_1234, 64'h0001_0001_0001_1111, 3'd2, 2'd1, 2'd0, 2'd2, "R9 shamt ignored avg");

        // random mix across all operations, modes, widths and shifts (R2 R3 R4 R5 R6 R7 R8)
        for (int n = 0; n < 3000; n++) begin
            apply({$urandom, $urandom}, {$urandom, $urandom}, 3'($urandom_range(0, 7)),
                  2'($urandom), 2'($urandom), 2'($urandom), "R2 random lanes");
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule